// File: doc/BRIEF.md
# Bad-Line Detector and CPU Bus Stall Generator

This block decides, cycle by cycle, whether the current raster line is a row-fetch line. On such a line the video controller must read 40 character pointers, and it has no spare bus slots for them. The block therefore drops the bus-available output to hold off the CPU. It also raises a fetch-window strobe during the 40 cycles in which the pointer reads take place.

The block receives the raster line and cycle counts from the timing generator, together with the vertical scroll field and the display-enable bit from the control register. The decision is combinational on these inputs, so a scroll write in the middle of a line creates or cancels a row-fetch line in the same cycle.

A sticky qualifier records whether display enable was high in any cycle of the arming line. The qualifier is cleared at line 0. A separate sprite DMA request input can also pull bus-available low.

Top module: `badline_stall`

## Requirements
- R1: `bad_line_o` can be 1 only when `line_i` is between 0x30 and 0xF7 inclusive, comparing all 9 bits of the line count.
- R2: `bad_line_o` requires `line_i[2:0]` to equal `yscroll_i`. The compare is combinational, so a change of `yscroll_i` part-way through a line sets or clears `bad_line_o` in that same cycle.
- R3: During line 0x30, any cycle with `den_i` = 1 arms the qualifier. The arming takes effect in that same cycle and stays in force for the rest of the frame, even if `den_i` falls again.
- R4: Line 0 clears the qualifier. If `den_i` stays 0 for every cycle of line 0x30, `bad_line_o` stays 0 for the rest of the frame, whatever `den_i` does later.
- R5: `fetch_win_o` is 1 exactly on cycles 15 to 54 inclusive (40 cycles) of a line where `bad_line_o` is 1, and 0 at all other times.
- R6: `ba_o` (1 = bus available to the CPU) is 0 on cycles 12 to 54 inclusive of a line where `bad_line_o` is 1. That is 3 lead cycles before the first fetch, 43 cycles in all. `ba_o` is 1 otherwise, unless R7 applies.
- R7: `spr_req_i` = 1 forces `ba_o` to 0 in any cycle, whatever the line state.
- R8: While `rst_ni` is low the qualifier is cleared. With `den_i` = 0 this gives `bad_line_o` = 0, `fetch_win_o` = 0 and `ba_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 9 | Current raster line |
| cycle_i | input | 7 | Cycle index within the line |
| yscroll_i | input | 3 | Vertical scroll field |
| den_i | input | 1 | Display enable bit |
| spr_req_i | input | 1 | Sprite DMA request for a bus stall |
| bad_line_o | output | 1 | Row-fetch line condition, current cycle |
| ba_o | output | 1 | Bus available to CPU (0 = stall) |
| fetch_win_o | output | 1 | Character-pointer fetch cycle |

## Verification
The bench goes after the following corner cases:
- **Inclusive range edges.** It probes lines 0x2F, 0x30, 0xF7, 0xF8 and 0x130. A design with an off-by-one range check, or one that drops line bit 8, would flag a row fetch outside the display area.
- **Scroll writes within a line.** It changes the scroll value in the middle of a line, once to create a row-fetch line and once to cancel one inside the stall window. A design that registers the condition once per line would be late by a whole line or would keep the CPU stalled.
- **Qualifier timing.** It raises display enable for a single late cycle of line 0x30, and it raises it only after line 0x30. A qualifier that is not sticky, or not cleared per frame, would miss real row fetches or invent them.
- **Window placement.** It checks every cycle of the stall and fetch windows. Wrong lead timing would let the CPU run into the first pointer reads.

// File: rtl/badline_pkg.sv
package badline_pkg;
  localparam int unsigned DEF_LINE_W      = 9;
  localparam int unsigned DEF_CYC_W       = 7;
  localparam int unsigned DEF_SCR_W       = 3;
  localparam int unsigned DEF_FIRST_LINE  = 'h30;
  localparam int unsigned DEF_LAST_LINE   = 'hF7;
  localparam int unsigned DEF_ARM_LINE    = 'h30;
  localparam int unsigned DEF_FETCH_START = 15;
  localparam int unsigned DEF_FETCH_LEN   = 40;
  localparam int unsigned DEF_BA_LEAD     = 3;

  typedef enum int unsigned {
    WIN_STALL = 0,
    WIN_FETCH = 1
  } win_e;
  localparam int unsigned NUM_WIN = 2;
endpackage

// File: rtl/badline_qual.sv
// Sticky display-enable qualifier: cleared at line 0, armed on the arm line.
module badline_qual #(
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned ARM_LINE = 'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic              den_i,
  output logic              qual_o
);
  localparam logic [LINE_W-1:0] ARM_C  = LINE_W'(ARM_LINE);
  localparam logic [LINE_W-1:0] ZERO_C = '0;

  logic armed_q;
  logic arm_now;

  assign arm_now = (line_i == ARM_C) && den_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 armed_q <= 1'b0;
    else if (line_i == ZERO_C)   armed_q <= 1'b0;
    else if (arm_now)            armed_q <= 1'b1;
  end

  // current cycle counts too, so arming is visible without a cycle of lag
  assign qual_o = armed_q | arm_now;
endmodule

// File: rtl/badline_cond.sv
module badline_cond #(
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned SCR_W      = 3,
  parameter int unsigned FIRST_LINE = 'h30,
  parameter int unsigned LAST_LINE  = 'hF7
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [SCR_W-1:0]  yscroll_i,
  input  logic              qual_i,
  output logic              bad_o
);
  localparam logic [LINE_W-1:0] FIRST_C = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] LAST_C  = LINE_W'(LAST_LINE);

  logic in_range;
  logic scroll_hit;

  assign in_range   = (line_i >= FIRST_C) && (line_i <= LAST_C);
  assign scroll_hit = (line_i[SCR_W-1:0] == yscroll_i);
  assign bad_o      = in_range && scroll_hit && qual_i;
endmodule

// File: rtl/badline_win.sv
module badline_win #(
  parameter int unsigned POS_W = 7,
  parameter int unsigned LO    = 12,
  parameter int unsigned HI    = 54
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             en_i,
  output logic             hit_o
);
  localparam logic [POS_W-1:0] LO_C = POS_W'(LO);
  localparam logic [POS_W-1:0] HI_C = POS_W'(HI);

  assign hit_o = en_i && (pos_i >= LO_C) && (pos_i <= HI_C);
endmodule

// File: rtl/badline_stall.sv
module badline_stall
  import badline_pkg::*;
#(
  parameter int unsigned LINE_W      = DEF_LINE_W,
  parameter int unsigned CYC_W       = DEF_CYC_W,
  parameter int unsigned SCR_W       = DEF_SCR_W,
  parameter int unsigned FIRST_LINE  = DEF_FIRST_LINE,
  parameter int unsigned LAST_LINE   = DEF_LAST_LINE,
  parameter int unsigned ARM_LINE    = DEF_ARM_LINE,
  parameter int unsigned FETCH_START = DEF_FETCH_START,
  parameter int unsigned FETCH_LEN   = DEF_FETCH_LEN,
  parameter int unsigned BA_LEAD     = DEF_BA_LEAD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic [SCR_W-1:0]  yscroll_i,
  input  logic              den_i,
  input  logic              spr_req_i,
  output logic              bad_line_o,
  output logic              ba_o,
  output logic              fetch_win_o
);
  localparam int unsigned FETCH_END = FETCH_START + FETCH_LEN - 1;
  localparam int unsigned BA_START  = FETCH_START - BA_LEAD;
  localparam int unsigned WIN_LO [NUM_WIN] = '{BA_START, FETCH_START};
  localparam int unsigned WIN_HI [NUM_WIN] = '{FETCH_END, FETCH_END};

  logic               qual;
  logic               bad;
  logic [NUM_WIN-1:0] win_hit;

  badline_qual #(
    .LINE_W  (LINE_W),
    .ARM_LINE(ARM_LINE)
  ) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .den_i (den_i),
    .qual_o(qual)
  );

  badline_cond #(
    .LINE_W    (LINE_W),
    .SCR_W     (SCR_W),
    .FIRST_LINE(FIRST_LINE),
    .LAST_LINE (LAST_LINE)
  ) u_cond (
    .line_i   (line_i),
    .yscroll_i(yscroll_i),
    .qual_i   (qual),
    .bad_o    (bad)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    badline_win #(
      .POS_W(CYC_W),
      .LO   (WIN_LO[g]),
      .HI   (WIN_HI[g])
    ) u_win (
      .pos_i(cycle_i),
      .en_i (bad),
      .hit_o(win_hit[g])
    );
  end

  assign bad_line_o  = bad;
  assign fetch_win_o = win_hit[WIN_FETCH];
  assign ba_o        = ~(win_hit[WIN_STALL] | spr_req_i);
endmodule

// File: rtl/badline_stall_chk.sv
module badline_stall_chk #(
  parameter int unsigned LINE_W      = 9,
  parameter int unsigned CYC_W       = 7,
  parameter int unsigned SCR_W       = 3,
  parameter int unsigned FIRST_LINE  = 'h30,
  parameter int unsigned LAST_LINE   = 'hF7,
  parameter int unsigned ARM_LINE    = 'h30,
  parameter int unsigned FETCH_START = 15,
  parameter int unsigned FETCH_LEN   = 40,
  parameter int unsigned BA_LEAD     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] line_i,
  input logic [CYC_W-1:0]  cycle_i,
  input logic [SCR_W-1:0]  yscroll_i,
  input logic              den_i,
  input logic              spr_req_i,
  input logic              bad_line_o,
  input logic              ba_o,
  input logic              fetch_win_o
);
  localparam logic [LINE_W-1:0] FIRST_C = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] LAST_C  = LINE_W'(LAST_LINE);
  localparam logic [LINE_W-1:0] ARM_C   = LINE_W'(ARM_LINE);
  localparam logic [CYC_W-1:0]  FS_C    = CYC_W'(FETCH_START);
  localparam logic [CYC_W-1:0]  FE_C    = CYC_W'(FETCH_START + FETCH_LEN - 1);
  localparam logic [CYC_W-1:0]  BS_C    = CYC_W'(FETCH_START - BA_LEAD);

  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_line_o |-> (line_i >= FIRST_C && line_i <= LAST_C));

  p_scroll_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_line_o |-> (line_i[SCR_W-1:0] == yscroll_i));

  p_arm_same_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i == ARM_C && den_i && line_i[SCR_W-1:0] == yscroll_i) |-> bad_line_o);

  p_fetch_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_win_o |-> (bad_line_o && cycle_i >= FS_C && cycle_i <= FE_C));

  p_fetch_stalls_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_win_o |-> !ba_o);

  p_lead_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_line_o && cycle_i == BS_C) |-> !ba_o);

  p_idle_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bad_line_o && !spr_req_i) |-> ba_o);

  p_sprite_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_req_i |-> !ba_o);
endmodule

bind badline_stall badline_stall_chk #(
  .LINE_W     (LINE_W),
  .CYC_W      (CYC_W),
  .SCR_W      (SCR_W),
  .FIRST_LINE (FIRST_LINE),
  .LAST_LINE  (LAST_LINE),
  .ARM_LINE   (ARM_LINE),
  .FETCH_START(FETCH_START),
  .FETCH_LEN  (FETCH_LEN),
  .BA_LEAD    (BA_LEAD)
) u_chk (.*);

// File: tb/badline_stall_test.sv
`timescale 1ns/1ps
module badline_stall_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] line_s = '0;
  logic [6:0] cyc_s = '0;
  logic [2:0] ys_s = '0;
  logic       den_s = 1'b0;
  logic       spr_s = 1'b0;
  logic       bad_w, ba_w, fetch_w;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  badline_stall uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line_s),
    .cycle_i    (cyc_s),
    .yscroll_i  (ys_s),
    .den_i      (den_s),
    .spr_req_i  (spr_s),
    .bad_line_o (bad_w),
    .ba_o       (ba_w),
    .fetch_win_o(fetch_w)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b line=%h cyc=%0d", req, what, act, exp, line_s, cyc_s);
    end
  endtask

  task automatic drive(int ln, int c, int ys, bit den, bit spr);
    @(negedge clk);
    line_s = 9'(ln); cyc_s = 7'(c); ys_s = 3'(ys); den_s = den; spr_s = spr;
    #2;
  endtask

  task automatic expect_cyc(string req, bit exp_bad);
    bit ef, eb;
    ef = exp_bad && cyc_s >= 15 && cyc_s <= 54;
    eb = !((exp_bad && cyc_s >= 12 && cyc_s <= 54) || spr_s);
    chk(req, "bad_line", bad_w, exp_bad);
    chk(req, "fetch_win", fetch_w, ef);
    chk(req, "ba", ba_w, eb);
  endtask

  task automatic run_line(string req, int ln, int ys, bit den, bit exp_bad);
    for (int c = 0; c < 63; c++) begin
      drive(ln, c, ys, den, 1'b0);
      expect_cyc(req, exp_bad);
    end
  endtask

  task automatic t_reset();
    drive(9'h30, 20, 0, 1'b0, 1'b0);
    expect_cyc("R8", 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_line();
    run_line("R4", 0, 0, 1'b1, 1'b0);
    run_line("R3_R5_R6", 9'h30, 0, 1'b1, 1'b1);
    run_line("R6", 9'h31, 0, 1'b1, 1'b0);
  endtask

  task automatic t_range();
    run_line("R1", 9'h28, 0, 1'b0, 1'b0);
    run_line("R1", 9'h2F, 7, 1'b0, 1'b0);
    run_line("R1", 9'h38, 0, 1'b0, 1'b1);
    run_line("R1", 9'hF0, 0, 1'b0, 1'b1);
    run_line("R1", 9'hF7, 7, 1'b0, 1'b1);
    run_line("R1", 9'hF8, 0, 1'b0, 1'b0);
    run_line("R1", 9'h130, 0, 1'b0, 1'b0);
  endtask

  task automatic t_scroll_mid();
    for (int c = 0; c < 63; c++) begin
      drive(9'h33, c, (c < 20) ? 0 : 3, 1'b0, 1'b0);
      expect_cyc("R2", c >= 20);
    end
    for (int c = 0; c < 63; c++) begin
      drive(9'h3B, c, (c < 40) ? 3 : 4, 1'b0, 1'b0);
      expect_cyc("R2", c < 40);
    end
  endtask

  task automatic t_frame_clear();
    run_line("R4", 0, 0, 1'b1, 1'b0);
    run_line("R4", 9'h30, 0, 1'b0, 1'b0);
    run_line("R4", 9'h38, 0, 1'b1, 1'b0);
    run_line("R4", 9'h40, 0, 1'b1, 1'b0);
  endtask

  task automatic t_late_den();
    run_line("R4", 0, 0, 1'b0, 1'b0);
    for (int c = 0; c < 63; c++) begin
      drive(9'h30, c, 0, c == 30, 1'b0);
      expect_cyc("R3", c >= 30);
    end
    run_line("R3", 9'h38, 0, 1'b0, 1'b1);
  endtask

  task automatic t_sprite();
    for (int c = 0; c < 63; c++) begin
      drive(9'h31, c, 0, 1'b0, (c < 6) || (c > 58));
      expect_cyc("R7", 1'b0);
    end
    for (int c = 50; c < 60; c++) begin
      drive(9'h40, c, 0, 1'b0, 1'b1);
      expect_cyc("R7", 1'b1);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_line();
    t_range();
    t_scroll_mid();
    t_sprite();
    t_frame_clear();
    t_late_den();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule